// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds the single atomic-access reservation of one processor core and sits in front of a small behavioural word memory. The core issues plain loads, plain stores, load-reserved and store-conditional requests on one request port. A load-reserved reads a word and records the 16-byte granule that contains it. A later store-conditional writes only while that reservation is still held, and it returns a registered pass/fail status. Software builds semaphores such as test-and-set and fetch-and-add on top of this pair.

A snoop port reports write attempts by other bus masters. A snoop write that lands anywhere inside the reserved granule cancels the reservation. Snoop writes do not change the memory in this block. Any store-conditional, to any address, uses up the reservation. A store-conditional does not compare its own address with the reserved one.

The reservation is tracked by a two-state machine with the states `RSV_EMPTY` and `RSV_HELD`. It has four named transitions:
- `T_ACQUIRE` (EMPTY to HELD) on an aligned load-reserved.
- `T_RELOAD` (HELD to HELD, new granule) on an aligned load-reserved.
- `T_CONSUME` (HELD to EMPTY) on an aligned store-conditional.
- `T_SNOOP_KILL` (HELD to EMPTY) on a snoop hit that arrives with no aligned load-reserved.

In every other case the state does not change.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset, `rsv_held`, `sc_done`, `sc_ok` and `align_err` are all 0.
- R2: An aligned load-reserved (`req_op` = 2'b10) sets `rsv_held` one cycle later. `rsv_granule` becomes `req_addr[ADDR_W-1:4]`, and `rsp_rdata` returns the addressed word in that same cycle.
- R3: A load-reserved issued while a reservation is held replaces the reserved granule with the new one. Only one reservation exists at a time.
- R4: An aligned store-conditional (`req_op` = 2'b11) issued while a reservation is held writes its data and reports `sc_ok`=1, even when its address lies outside the reserved granule.
- R5: A store-conditional issued with no reservation leaves memory unchanged and reports `sc_ok`=0.
- R6: Every aligned store-conditional clears the reservation, whether it succeeds or fails.
- R7: A snoop write whose address falls in the reserved 16-byte granule (bits 3:0 ignored) clears the reservation. A snoop write outside that granule leaves it held.
- R8: A load-reserved or store-conditional with `req_addr[1:0]` not equal to 0 is misaligned. It raises `align_err` for exactly the following cycle. It does not change the reservation and does not write memory, and a misaligned store-conditional reports failure.
- R9: When a snoop hit on the reserved granule and a store-conditional arrive in the same cycle, the snoop wins. The store-conditional fails and does not write.
- R10: When a snoop hit and an aligned load-reserved arrive in the same cycle, the load-reserved wins and the new reservation is held.
- R11: Plain loads (2'b00) and plain stores (2'b01) from the core read and write the memory and leave the reservation intact.
- R12: `sc_done` is 1 exactly in the cycle after a store-conditional request. `sc_ok` is only ever 1 together with `sc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_op | input | 2 | 00 load, 01 store, 10 load-reserved, 11 store-conditional |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data |
| snoop_valid | input | 1 | Another master is attempting a write |
| snoop_addr | input | ADDR_W | Byte address of that write |
| rsp_rdata | output | DATA_W | Registered read data for loads |
| sc_done | output | 1 | Store-conditional status valid |
| sc_ok | output | 1 | Store-conditional succeeded |
| align_err | output | 1 | One-cycle misaligned-request flag |
| rsv_held | output | 1 | Reservation currently valid |
| rsv_granule | output | ADDR_W-4 | Reserved granule address |

## Verification
The bench builds the block with `ADDR_W`=8 and `MEM_WORDS`=64, so every byte address maps to exactly one stored word with no aliasing. This lets the reference model mirror the whole memory and read back every word. With only 16 granules, random snoop traffic hits the reserved granule often, so snoop-versus-request collisions occur frequently in the mixed phase as well as in the directed cases.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'b00,
        OP_STORE  = 2'b01,
        OP_LDRSV  = 2'b10,
        OP_STCOND = 2'b11
    } lrsc_op_e;

    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_HELD  = 1'b1
    } rsv_state_e;

    typedef struct packed {
        logic is_load;
        logic is_store;
        logic is_lr;
        logic is_sc;
        logic misaligned;
    } req_class_t;

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
    import lrsc_pkg::*;
(
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic [1:0] addr_lo,
    output req_class_t cls
);
    lrsc_op_e op;
    logic     atomic;

    always_comb begin
        op     = lrsc_op_e'(req_op);
        atomic = req_valid && (op == OP_LDRSV || op == OP_STCOND);
        cls    = '0;
        if (req_valid) begin
            unique case (op)
                OP_LOAD:   cls.is_load  = 1'b1;
                OP_STORE:  cls.is_store = 1'b1;
                OP_LDRSV:  cls.is_lr    = 1'b1;
                OP_STCOND: cls.is_sc    = 1'b1;
                default:   cls          = '0;
            endcase
        end
        cls.misaligned = atomic && (addr_lo != 2'b00);
    end
endmodule

// File: rtl/lrsc_resv_fsm.sv
module lrsc_resv_fsm
    import lrsc_pkg::*;
#(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  req_class_t    cls,
    input  logic [GW-1:0] req_gran,
    input  logic          snoop_valid,
    input  logic [GW-1:0] snoop_gran,
    output logic          held,
    output logic [GW-1:0] granule,
    output logic          sc_grant
);
    rsv_state_e    state_q, state_d;
    logic [GW-1:0] gran_q, gran_d;
    logic          lr_ok, sc_aligned, snoop_hit;

    assign lr_ok      = cls.is_lr && !cls.misaligned;
    assign sc_aligned = cls.is_sc && !cls.misaligned;
    assign snoop_hit  = snoop_valid && (state_q == RSV_HELD) && (snoop_gran == gran_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
            gran_q  <= '0;
        end else begin
            state_q <= state_d;
            gran_q  <= gran_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        gran_d  = gran_q;
        unique case (state_q)
            RSV_EMPTY: begin
                if (lr_ok) begin            // T_ACQUIRE
                    state_d = RSV_HELD;
                    gran_d  = req_gran;
                end
            end
            RSV_HELD: begin
                if (lr_ok) begin            // T_RELOAD (wins over snoop)
                    state_d = RSV_HELD;
                    gran_d  = req_gran;
                end else if (sc_aligned) begin  // T_CONSUME
                    state_d = RSV_EMPTY;
                end else if (snoop_hit) begin   // T_SNOOP_KILL
                    state_d = RSV_EMPTY;
                end
            end
            default: state_d = RSV_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        held     = (state_q == RSV_HELD);
        granule  = gran_q;
        sc_grant = 1'b0;
        unique case (state_q)
            RSV_EMPTY: sc_grant = 1'b0;
            RSV_HELD:  sc_grant = sc_aligned && !snoop_hit;
            default:   sc_grant = 1'b0;
        endcase
    end
endmodule

// File: rtl/lrsc_mem.sv
module lrsc_mem #(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 64,
    localparam int IDX_W    = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store_q [MEM_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) store_q[idx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= store_q[idx];
    end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 64,
    parameter int GRAN_LG   = 4,
    localparam int GW       = ADDR_W - GRAN_LG,
    localparam int IDX_W    = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sc_done,
    output logic              sc_ok,
    output logic              align_err,
    output logic              rsv_held,
    output logic [GW-1:0]     rsv_granule
);
    req_class_t cls;
    logic       sc_grant;
    logic       wr_en, rd_en;
    logic       unused_lo;

    assign unused_lo = ^{snoop_addr[GRAN_LG-1:0], req_addr[GRAN_LG-1:2]};

    lrsc_decode u_dec (
        .req_valid (req_valid),
        .req_op    (req_op),
        .addr_lo   (req_addr[1:0]),
        .cls       (cls)
    );

    lrsc_resv_fsm #(.GW(GW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cls         (cls),
        .req_gran    (req_addr[ADDR_W-1:GRAN_LG]),
        .snoop_valid (snoop_valid),
        .snoop_gran  (snoop_addr[ADDR_W-1:GRAN_LG]),
        .held        (rsv_held),
        .granule     (rsv_granule),
        .sc_grant    (sc_grant)
    );

    assign wr_en = cls.is_store || sc_grant;
    assign rd_en = cls.is_load || (cls.is_lr && !cls.misaligned);

    lrsc_mem #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .idx   (req_addr[IDX_W+1:2]),
        .wdata (req_wdata),
        .rdata (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_done   <= 1'b0;
            sc_ok     <= 1'b0;
            align_err <= 1'b0;
        end else begin
            sc_done   <= cls.is_sc;
            sc_ok     <= sc_grant;
            align_err <= cls.misaligned;
        end
    end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
    parameter int ADDR_W  = 12,
    parameter int GRAN_LG = 4,
    localparam int GW     = ADDR_W - GRAN_LG
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              snoop_valid,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              sc_done,
    input logic              sc_ok,
    input logic              align_err,
    input logic              rsv_held,
    input logic [GW-1:0]     rsv_granule
);
    logic is_lr, is_sc, aligned, hit, unused_chk;

    assign unused_chk = ^{req_addr[GRAN_LG-1:2], snoop_addr[GRAN_LG-1:0]};
    assign aligned = (req_addr[1:0] == 2'b00);
    assign is_lr   = req_valid && (req_op == 2'b10);
    assign is_sc   = req_valid && (req_op == 2'b11);
    assign hit     = snoop_valid && rsv_held &&
                     (snoop_addr[ADDR_W-1:GRAN_LG] == rsv_granule);

    p_lr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lr && aligned) |=> (rsv_held && rsv_granule == $past(req_addr[ADDR_W-1:GRAN_LG])));

    p_sc_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && aligned && rsv_held && !hit) |=> sc_ok);

    p_sc_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && !rsv_held) |=> (sc_done && !sc_ok));

    p_sc_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && aligned) |=> !rsv_held);

    p_snoop_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !(is_lr && aligned)) |=> !rsv_held);

    p_misalign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_lr || is_sc) && !aligned && !hit) |=> (align_err && $stable(rsv_held) && !sc_ok));

    p_snoop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && hit) |=> !sc_ok);

    p_lr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lr && aligned && snoop_valid) |=> rsv_held);

    p_done_timing_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done |-> $past(is_sc));

    p_ok_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok |-> sc_done);
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .sc_done     (sc_done),
    .sc_ok       (sc_ok),
    .align_err   (align_err),
    .rsv_held    (rsv_held),
    .rsv_granule (rsv_granule)
);

// File: tb/sim_lrsc_monitor.sv
module sim_lrsc_monitor;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic [DW-1:0] rsp_rdata;
    logic          sc_done, sc_ok, align_err, rsv_held;
    logic [AW-5:0] rsv_granule;

    always #5 clk = ~clk;

    lrsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .MEM_WORDS(NW), .GRAN_LG(4)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .rsp_rdata(rsp_rdata), .sc_done(sc_done),
        .sc_ok(sc_ok), .align_err(align_err), .rsv_held(rsv_held),
        .rsv_granule(rsv_granule)
    );

    // reference model state
    logic [DW-1:0] m_mem [NW];
    bit            m_held = 0;
    int            m_gran = 0;
    logic [DW-1:0] m_rdata = '0;
    bit            m_rd_chk = 0;
    bit            m_done = 0, m_ok = 0, m_aerr = 0;
    int            vectors = 0;
    int            miscompares = 0;

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit v, input logic [1:0] op, input int addr,
                        input logic [DW-1:0] wd, input bit sv, input int saddr);
        bit lsc, mis, hit;
        req_valid   = v;
        req_op      = op;
        req_addr    = AW'(addr);
        req_wdata   = wd;
        snoop_valid = sv;
        snoop_addr  = AW'(saddr);
        @(posedge clk);
        lsc = v && (op == 2'b10 || op == 2'b11);
        mis = lsc && (addr % 4 != 0);
        hit = sv && m_held && ((saddr / 16) == m_gran);
        m_aerr   = mis;
        m_done   = v && op == 2'b11;
        m_ok     = m_done && !mis && m_held && !hit;
        m_rd_chk = v && (op == 2'b00 || (op == 2'b10 && !mis));
        if (m_rd_chk) m_rdata = m_mem[addr / 4];
        if ((v && op == 2'b01) || m_ok) m_mem[addr / 4] = wd;
        if (v && op == 2'b10 && !mis) begin
            m_held = 1;
            m_gran = addr / 16;
        end else if (v && op == 2'b11 && !mis) begin
            m_held = 0;
        end else if (hit) begin
            m_held = 0;
        end
        @(negedge clk);
        vectors++;
        cmp(tag, "rsv_held", int'(rsv_held), int'(m_held));
        cmp(tag, "sc_done", int'(sc_done), int'(m_done));
        cmp(tag, "sc_ok", int'(sc_ok), int'(m_ok));
        cmp(tag, "align_err", int'(align_err), int'(m_aerr));
        if (m_held) cmp(tag, "rsv_granule", int'(rsv_granule), m_gran);
        if (m_rd_chk) cmp(tag, "rsp_rdata", int'(rsp_rdata), int'(m_rdata));
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 2'b00, 0, '0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int seed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        // R11: fill memory with plain stores, read some back
        for (int i = 0; i < NW; i++) step("R11 fill", 1, 2'b01, i * 4, 32'hC0DE_0000 + DW'(i * 7), 0, 0);
        step("R11 load", 1, 2'b00, 8, '0, 0, 0);
        step("R11 load", 1, 2'b00, 252, '0, 0, 0);
        // R5: no reservation, SC fails and leaves memory
        step("R5 sc no rsv", 1, 2'b11, 16, 32'hDEAD_0001, 0, 0);
        step("R5 readback", 1, 2'b00, 16, '0, 0, 0);
        // R2: acquire
        step("R2 lr", 1, 2'b10, 32, '0, 0, 0);
        // R11: plain store keeps reservation
        step("R11 store keeps", 1, 2'b01, 36, 32'h1111_2222, 0, 0);
        // R7: snoop outside keeps
        step("R7 snoop outside", 0, 2'b00, 0, '0, 1, 128);
        // R4/R6: SC to other address succeeds, clears
        step("R4 R6 sc other addr", 1, 2'b11, 64, 32'hBEEF_0004, 0, 0);
        step("R4 readback", 1, 2'b00, 64, '0, 0, 0);
        step("R6 sc after consume", 1, 2'b11, 64, 32'h0BAD_0BAD, 0, 0);
        step("R5 readback2", 1, 2'b00, 64, '0, 0, 0);
        // R3: reservation replaced
        step("R3 lr a", 1, 2'b10, 48, '0, 0, 0);
        step("R3 lr b", 1, 2'b10, 80, '0, 0, 0);
        step("R3 old granule snoop", 0, 2'b00, 0, '0, 1, 48);
        step("R7 snoop in granule", 0, 2'b00, 0, '0, 1, 92);
        // R10: LR and snoop same cycle
        step("R10 lr vs snoop", 1, 2'b10, 96, '0, 1, 100);
        // R9: SC and snoop hit same cycle
        step("R9 sc vs snoop", 1, 2'b11, 96, 32'h5555_AAAA, 1, 111);
        step("R9 readback", 1, 2'b00, 96, '0, 0, 0);
        // R8: misaligned
        step("R8 lr misaligned", 1, 2'b10, 114, '0, 0, 0);
        idle("R8 pulse ends");
        step("R8 lr", 1, 2'b10, 112, '0, 0, 0);
        step("R8 sc misaligned", 1, 2'b11, 113, 32'h7777_7777, 0, 0);
        step("R8 readback", 1, 2'b00, 112, '0, 0, 0);
        // R12 / R9 snoop elsewhere does not block
        step("R9 sc snoop miss", 1, 2'b11, 112, 32'h9999_0000, 1, 0);
        idle("R12 done clears");
        step("R12 readback", 1, 2'b00, 112, '0, 0, 0);
        // mixed traffic
        seed = 32'h1234_5678;
        for (int n = 0; n < 3000; n++) begin
            int r1, r2, r3;
            seed = seed * 1103515245 + 12345; r1 = (seed >>> 8) & 32'hFFFF;
            seed = seed * 1103515245 + 12345; r2 = (seed >>> 8) & 32'hFFFF;
            seed = seed * 1103515245 + 12345; r3 = (seed >>> 8) & 32'hFFFF;
            step("R12 mixed", (r1 & 7) != 0, 2'(r1 >> 3), (r2 & 8'hFF) & (((r1 >> 5) & 7) == 0 ? 8'hFF : 8'hFC),
                 DW'(r3 * 40503), (r3 & 3) == 0, r2 >> 8);
        end
        idle("R12 end");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule